// File: doc/BRIEF.md
# Two-Device Cable Cycle Timing Selector

This block sits on the host side of a parallel drive cable that two devices share. Each device has its own fastest transfer mode, held in a configuration input. For each requested bus cycle the block picks the timing mode. Register accesses always run at the slower device's mode. A data access runs at its target device's own mode only when its chip-select and device-address lines match those of the data cycle just before it. Otherwise the data access falls back to the slower mode.

Once a request is accepted, the block drives the read or write strobe low for an active period and then holds it high for a recovery period. Both periods depend on the chosen mode. A one-clock done pulse ends the cycle, and only after that is a new request taken. The block also reports whether DMA may be used toward the addressed device. DMA is allowed only when the other device on the cable understands the DMA control lines.

Top module: `dual_dev_cycle_timer`

## Requirements
- R1: While reset is active and in the first cycle after it, `req_ready` is 1, `rd_n` and `wr_n` are 1, `cycle_done` is 0 and `sel_mode` is 0.
- R2: A register access (`req_is_data`=0) runs at the lower of the two devices' modes.
- R3: A data access (`req_is_data`=1) runs at the target device's mode when its `req_cs`/`req_da` equal those of the previous accepted cycle, and that previous cycle was also a data access. The target is device 0 when `req_dev`=0 and device 1 when `req_dev`=1.
- R4: A data access runs at the lower of the two devices' modes if any of these holds: it is the first cycle after reset, it follows a register access, or its `req_cs`/`req_da` differ from those of the previous cycle.
- R5: Modes are encoded 0 (slowest) to 4 (fastest). A configured mode value above 4 is treated as 4.
- R6: For a cycle run at mode m, the strobe goes low for 2*(5-m) clocks, starting the clock after acceptance. `rd_n` is the strobe for reads (`req_write`=0) and `wr_n` for writes. The other strobe stays high, and the two are never low together.
- R7: After the active period, both strobes stay high for 5-m clocks. Then `cycle_done` is 1 for exactly one clock.
- R8: `req_ready` is 0 from the clock after acceptance through the done clock, and no request is taken in that time. It returns to 1 on the clock after `cycle_done`.
- R9: `sel_mode` takes the chosen mode on the clock after acceptance and holds it until the next acceptance.
- R10: `dma_permit` equals `dev1_dma_ok` when `req_dev`=0 and `dev0_dma_ok` when `req_dev`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cycle request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_is_data | input | 1 | 1 = data access, 0 = register access |
| req_cs | input | 2 | Chip-select field of the cycle |
| req_da | input | 3 | Device-address field of the cycle |
| req_dev | input | 1 | Target device |
| dev0_mode | input | 3 | Fastest mode of device 0 |
| dev1_mode | input | 3 | Fastest mode of device 1 |
| dev0_dma_ok | input | 1 | Device 0 supports a DMA mode |
| dev1_dma_ok | input | 1 | Device 1 supports a DMA mode |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| sel_mode | output | 3 | Mode of the current or last cycle |
| cycle_done | output | 1 | One-clock end-of-cycle pulse |
| dma_permit | output | 1 | DMA allowed toward the target device |

## Verification
Some properties are checked on every clock. The two strobes never overlap, and neither is low while `req_ready` is high. The done pulse lasts one clock and is followed by ready. `sel_mode` stays still while a cycle runs and never exceeds 4. A register access never gets a mode faster than either device's. The exact mode choice cannot be seen on a single clock, because it depends on the address history since reset and the last register access. The same holds for the exact active and recovery lengths. These are shown by the bench's cycle sequences, which measure each strobe period and compare the mode against a value worked out by hand.

// File: rtl/dctm_pkg.sv
// Shared constants and types for the two-device cycle timing selector.
// Assumes modes fit in MODE_W bits and that the mode table is computed, not stored.
package dctm_pkg;
    localparam int MODE_W = 3;
    localparam int ADDR_W = 5;   // 2-bit chip select plus 3-bit device address

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_RECOV  = 2'd2,
        PH_DONE   = 2'd3
    } phase_t;
endpackage

// File: rtl/dctm_mode_pick.sv
// Picks the timing mode for the request being offered.
// Register accesses use the slower device's mode. Data accesses use the target's
// mode only when the address matches the previous data cycle. Assumes mode values
// above MAX_MODE mean MAX_MODE.
module dctm_mode_pick #(
    parameter int MAX_MODE = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic                        is_data,
    input  logic                        dev,
    input  logic [1:0]                  cs,
    input  logic [2:0]                  da,
    input  logic [dctm_pkg::MODE_W-1:0] dev0_mode,
    input  logic [dctm_pkg::MODE_W-1:0] dev1_mode,
    output logic [dctm_pkg::MODE_W-1:0] mode_next
);
    import dctm_pkg::*;

    localparam logic [MODE_W-1:0] MODE_CAP = MODE_W'(MAX_MODE);

    logic [MODE_W-1:0] m0_eff, m1_eff, slow_mode, tgt_mode;
    logic [ADDR_W-1:0] last_addr;
    logic              last_valid;
    logic              addr_same;

    // Clamp the configured modes and find the slower one and the target's.
    always_comb begin
        m0_eff    = (dev0_mode > MODE_CAP) ? MODE_CAP : dev0_mode;
        m1_eff    = (dev1_mode > MODE_CAP) ? MODE_CAP : dev1_mode;
        slow_mode = (m0_eff < m1_eff) ? m0_eff : m1_eff;
        tgt_mode  = dev ? m1_eff : m0_eff;
    end

    // Choose full speed only for a data access that repeats the last data address.
    always_comb begin
        addr_same = last_valid && (last_addr == {cs, da});
        mode_next = (is_data && addr_same) ? tgt_mode : slow_mode;
    end

    // Remember the address of the last data access. A register access forgets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr  <= '0;
            last_valid <= 1'b0;
        end else if (accept) begin
            last_addr  <= {cs, da};
            last_valid <= is_data;
        end
    end
endmodule

// File: rtl/dctm_strobe_timer.sv
// Runs one bus cycle: the strobe is low for the active count, high for the recovery
// count, then a one-clock done pulse. Counts fall linearly as the mode number rises.
// Assumes start is asserted only while ready is high.
module dctm_strobe_timer #(
    parameter int MAX_MODE = 4,
    parameter int ACT_STEP = 2,
    parameter int REC_STEP = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        start_write,
    input  logic [dctm_pkg::MODE_W-1:0] start_mode,
    output logic                        ready,
    output logic                        rd_n,
    output logic                        wr_n,
    output logic                        done,
    output logic [dctm_pkg::MODE_W-1:0] cur_mode
);
    import dctm_pkg::*;

    localparam int MAX_CNT = ACT_STEP * (MAX_MODE + 1) + REC_STEP * (MAX_MODE + 1);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  act_load, rec_load;
    logic              is_write;

    // Active count for the new request, and recovery count for the latched mode.
    always_comb begin
        act_load = CNT_W'(ACT_STEP * (MAX_MODE + 1 - int'(start_mode)) - 1);
        rec_load = CNT_W'(REC_STEP * (MAX_MODE + 1 - int'(cur_mode)) - 1);
    end

    // Step the phase sequence and the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            cur_mode <= '0;
            is_write <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_ACTIVE;
                    cnt      <= act_load;
                    cur_mode <= start_mode;
                    is_write <= start_write;
                end
                PH_ACTIVE: if (cnt == '0) begin
                    phase <= PH_RECOV;
                    cnt   <= rec_load;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_RECOV: if (cnt == '0) begin
                    phase <= PH_DONE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decode the outputs from the phase.
    always_comb begin
        ready = (phase == PH_IDLE);
        done  = (phase == PH_DONE);
        rd_n  = !((phase == PH_ACTIVE) && !is_write);
        wr_n  = !((phase == PH_ACTIVE) && is_write);
    end
endmodule

// File: rtl/dual_dev_cycle_timer.sv
// Top level. Accepts cycle requests for a cable shared by two devices, picks the
// timing mode for each one and runs the strobe. It also reports whether DMA may
// be used toward the target device. Assumes the request fields stay steady while
// req_valid is high.
module dual_dev_cycle_timer #(
    parameter int MAX_MODE = 4,
    parameter int ACT_STEP = 2,
    parameter int REC_STEP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  logic       req_is_data,
    input  logic [1:0] req_cs,
    input  logic [2:0] req_da,
    input  logic       req_dev,
    input  logic [2:0] dev0_mode,
    input  logic [2:0] dev1_mode,
    input  logic       dev0_dma_ok,
    input  logic       dev1_dma_ok,
    output logic       rd_n,
    output logic       wr_n,
    output logic [2:0] sel_mode,
    output logic       cycle_done,
    output logic       dma_permit
);
    import dctm_pkg::*;

    logic              accept;
    logic [MODE_W-1:0] mode_next;

    // A request is taken only while the timer is idle.
    always_comb begin
        accept     = req_valid && req_ready;
        dma_permit = req_dev ? dev0_dma_ok : dev1_dma_ok;
    end

    dctm_mode_pick #(.MAX_MODE(MAX_MODE)) pick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .is_data   (req_is_data),
        .dev       (req_dev),
        .cs        (req_cs),
        .da        (req_da),
        .dev0_mode (dev0_mode),
        .dev1_mode (dev1_mode),
        .mode_next (mode_next)
    );

    dctm_strobe_timer #(
        .MAX_MODE (MAX_MODE),
        .ACT_STEP (ACT_STEP),
        .REC_STEP (REC_STEP)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_write (req_write),
        .start_mode  (mode_next),
        .ready       (req_ready),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .done        (cycle_done),
        .cur_mode    (sel_mode)
    );
endmodule

// File: rtl/dual_dev_cycle_timer_chk.sv
// Checker bound to the top level. It watches only ports.
module dual_dev_cycle_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_is_data,
    input logic       req_dev,
    input logic [2:0] dev0_mode,
    input logic [2:0] dev1_mode,
    input logic       dev0_dma_ok,
    input logic       dev1_dma_ok,
    input logic       rd_n,
    input logic       wr_n,
    input logic [2:0] sel_mode,
    input logic       cycle_done,
    input logic       dma_permit
);
    // R6: the two strobes never go low together.
    assert_no_strobe_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R8: no strobe is driven while the block reports ready.
    assert_busy_when_strobing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !req_ready);

    // R7: the done pulse lasts one clock.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R8: ready comes back right after done.
    assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> req_ready);

    // R9: the mode holds while a cycle is in progress.
    assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$rose(!req_ready)) |-> $stable(sel_mode));

    // R5: the mode never goes above the fastest encoding.
    assert_mode_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_mode <= 3'd4);

    // R2: a register access never runs faster than either device.
    assert_reg_slow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_is_data && $stable(dev0_mode) && $stable(dev1_mode))
        |=> (sel_mode <= dev0_mode && sel_mode <= dev1_mode));

    // R10: DMA is only allowed when at least one device supports it.
    assert_dma_needs_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_permit && !req_dev) |-> (dev1_dma_ok || dev0_dma_ok));
endmodule

bind dual_dev_cycle_timer dual_dev_cycle_timer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_is_data (req_is_data),
    .req_dev     (req_dev),
    .dev0_mode   (dev0_mode),
    .dev1_mode   (dev1_mode),
    .dev0_dma_ok (dev0_dma_ok),
    .dev1_dma_ok (dev1_dma_ok),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .sel_mode    (sel_mode),
    .cycle_done  (cycle_done),
    .dma_permit  (dma_permit)
);

// File: tb/dual_dev_cycle_timer_tb_top.sv
// Bench: a table of request vectors with expected modes, then directed tests.
module dual_dev_cycle_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic       req_is_data = 1'b0;
    logic [1:0] req_cs = '0;
    logic [2:0] req_da = '0;
    logic       req_dev = 1'b0;
    logic [2:0] dev0_mode = 3'd4;
    logic [2:0] dev1_mode = 3'd1;
    logic       dev0_dma_ok = 1'b0;
    logic       dev1_dma_ok = 1'b0;
    logic       rd_n, wr_n, cycle_done, dma_permit;
    logic [2:0] sel_mode;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    dual_dev_cycle_timer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_is_data(req_is_data), .req_cs(req_cs),
        .req_da(req_da), .req_dev(req_dev), .dev0_mode(dev0_mode),
        .dev1_mode(dev1_mode), .dev0_dma_ok(dev0_dma_ok), .dev1_dma_ok(dev1_dma_ok),
        .rd_n(rd_n), .wr_n(wr_n), .sel_mode(sel_mode), .cycle_done(cycle_done),
        .dma_permit(dma_permit)
    );

    // Vector: [10] data, [9] dev, [8] write, [7:6] cs, [5:3] da, [2:0] expected mode.
    // Device 0 mode 4, device 1 mode 1, so the slower mode is 1.
    localparam int NVEC = 12;
    localparam logic [10:0] VEC [NVEC] = '{
        11'b1_0_0_01_000_001,   // R4 first after reset
        11'b1_0_0_01_000_100,   // R3 same address
        11'b1_0_0_01_000_100,   // R3
        11'b1_0_0_01_001_001,   // R4 address changed
        11'b1_0_0_01_001_100,   // R3
        11'b0_0_0_01_111_001,   // R2 register access
        11'b1_0_0_01_001_001,   // R4 after register access
        11'b1_1_0_01_001_001,   // R3 target dev1 at its own mode 1
        11'b1_1_0_01_001_001,   // R3
        11'b1_0_0_01_001_100,   // R3 dev0 same address
        11'b1_0_1_10_110_001,   // R4 write, new address
        11'b1_0_1_10_110_100    // R3 write
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one cycle and measure it against the expected mode.
    task automatic run_cycle(input bit is_data, input bit dev, input bit wr,
                             input logic [1:0] cs, input logic [2:0] da,
                             input int exp_mode);
        int lows = 0;
        int highs = 0;
        int guard = 0;
        bit other_low = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        req_is_data = is_data; req_dev = dev; req_write = wr;
        req_cs = cs; req_da = da; req_valid = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b0, "R8 ready low in cycle", req_ready, 0);
        check(sel_mode == 3'(exp_mode), "R2/R3/R4 mode", sel_mode, exp_mode);
        while ((wr ? !wr_n : !rd_n) && guard < 200) begin
            lows++;
            if (wr ? !rd_n : !wr_n) other_low = 1;
            // R8: keep requesting while busy; nothing may be taken
            @(negedge clk);
            guard++;
            check(sel_mode == 3'(exp_mode), "R9 mode held", sel_mode, exp_mode);
        end
        req_valid = 1'b0;
        while (!cycle_done && guard < 200) begin
            highs++;
            if (!rd_n || !wr_n) other_low = 1;
            @(negedge clk);
            guard++;
        end
        check(lows == 2 * (5 - exp_mode), "R6 active length", lows, 2 * (5 - exp_mode));
        check(highs == 5 - exp_mode, "R7 recovery length", highs, 5 - exp_mode);
        check(!other_low, "R6 other strobe high", other_low, 0);
        @(negedge clk);
        check(req_ready && !cycle_done, "R7 done one clock, R8 ready back", req_ready, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(req_ready && rd_n && wr_n && !cycle_done && sel_mode == 0, "R1 in reset",
              {req_ready, rd_n, wr_n, cycle_done}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && rd_n && wr_n && !cycle_done && sel_mode == 0, "R1 after reset",
              sel_mode, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:6], VEC[i][5:3],
                      int'(VEC[i][2:0]));
        end

        // R5: values above 4 act as 4
        dev0_mode = 3'd7; dev1_mode = 3'd6;
        run_cycle(1'b0, 1'b0, 1'b0, 2'b01, 3'b010, 4);
        run_cycle(1'b1, 1'b1, 1'b1, 2'b01, 3'b000, 4);

        // R3 with target dev1 faster than dev0
        dev0_mode = 3'd0; dev1_mode = 3'd3;
        run_cycle(1'b1, 1'b1, 1'b0, 2'b10, 3'b000, 0);
        run_cycle(1'b1, 1'b1, 1'b0, 2'b10, 3'b000, 3);
        run_cycle(1'b1, 1'b1, 1'b0, 2'b11, 3'b000, 0);  // R4 cs change only

        // R10: DMA follows the other device
        for (int k = 0; k < 8; k++) begin
            req_dev = k[0]; dev0_dma_ok = k[1]; dev1_dma_ok = k[2];
            #1;
            check(dma_permit == (k[0] ? k[1] : k[2]), "R10 dma permit", dma_permit,
                  k[0] ? k[1] : k[2]);
            @(negedge clk);
        end

        // R1: reset in the middle of a cycle
        req_is_data = 1'b1; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(req_ready && rd_n && wr_n && sel_mode == 0, "R1 reset mid-cycle", wr_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        dev0_mode = 3'd4; dev1_mode = 3'd2;
        run_cycle(1'b1, 1'b0, 1'b0, 2'b10, 3'b000, 2);  // R4 first after reset again

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule